// File: doc/BRIEF.md
# Write-Through Store Buffer

This block is a short first-in first-out queue that sits between a write-through data cache and a slow main memory. Each processor store writes the cache and, in the same operation, pushes its word address, data and byte enables into the queue. The memory controller takes the oldest queued store whenever memory can accept a write, so stores reach memory in program order and at the memory's own pace. When the queue is saturated the block raises a full flag, and the processor must stall instead of dropping a store.

Because a store can still be waiting in the queue when a later read misses in the cache, the block also offers a lookup port. A read-miss address is compared, at word granularity, with every occupied entry at once. The youngest matching entry decides the result one cycle later. If it has all byte enables set, it returns its data as a forwarding hit. If it does not, a partial flag tells the requester to wait until the queue has drained that entry.

Top module: `wt_store_buf`

## Requirements
- R1: During and right after synchronous reset, `empty` is 1, `full` is 0, `drain_valid` is 0 and both lookup flags are 0.
- R2: Entries leave in the order they were accepted. While `drain_valid` is 1, the drain outputs show the address, data and byte enables of the oldest entry.
- R3: The queue holds 4 entries. After 4 accepted stores with no drain, `full` reads 1 from the next cycle on.
- R4: A store offered while `full` is 1 and `drain_ready` is 0 is dropped. Occupancy and contents stay unchanged, and a later lookup of its address misses.
- R5: A store and a drain in the same cycle while `full` is 1 are both accepted. `full` stays 1 and the new store becomes the youngest entry.
- R6: `drain_ready` while `empty` is 1 has no effect, and `empty` stays 1.
- R7: The flags are registered from occupancy. After a drain with no store from a full queue, `full` reads 0 in the next cycle. `empty` reads 1 exactly when occupancy is zero.
- R8: Lookup compares address bits [31:2] of `probe_addr` with every occupied entry. If the youngest match has byte enables 4'b1111, then in the next cycle `probe_hit` is 1 and `probe_data` carries that entry's data.
- R9: If the youngest match has any byte enable clear, then in the next cycle `probe_partial` is 1 and `probe_hit` is 0.
- R10: With no request, or with no matching entry, both `probe_hit` and `probe_partial` are 0 in the next cycle.
- R11: A lookup sees the contents as they stood in the request cycle. A store accepted in that cycle is not seen, and an entry drained in that cycle is still seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Processor offers a store |
| st_addr | input | 32 | Store address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables |
| full | output | 1 | Queue saturated; processor must stall |
| empty | output | 1 | Queue holds no entry |
| drain_ready | input | 1 | Memory accepts the oldest entry this cycle |
| drain_valid | output | 1 | Oldest entry is present |
| drain_addr | output | 32 | Address of the oldest entry |
| drain_data | output | 32 | Data of the oldest entry |
| drain_be | output | 4 | Byte enables of the oldest entry |
| probe_req | input | 1 | Read-miss lookup request |
| probe_addr | input | 32 | Read-miss address |
| probe_hit | output | 1 | Youngest match is complete; data forwarded |
| probe_partial | output | 1 | Youngest match is incomplete; wait for drain |
| probe_data | output | 32 | Forwarded data, valid with `probe_hit` |

## Verification
The assertions assume that the inputs hold known values after reset, and that the processor may offer stores while `full` is set or ask for a drain while `empty` is set. The block must tolerate both, and the properties on full and empty behaviour depend on that. The stimulus follows the same assumptions. Directed phases deliberately offer stores into a full queue and drain requests on an empty one. A random phase draws addresses from a small pool of words, so that lookups meet several matches of mixed byte coverage, often in the same cycle as a store or a drain.

// File: rtl/wtsb_pkg.sv
package wtsb_pkg;

  typedef enum logic [1:0] {
    LK_NONE = 2'd0,
    LK_FULL = 2'd1,
    LK_PART = 2'd2
  } lk_res_e;

  function automatic int ring_next(input int ptr, input int depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/wtsb_ctrl.sv
module wtsb_ctrl #(
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_valid,
  input  logic          drain_ready,
  output logic          push_fire,
  output logic          pop_fire,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [CW-1:0] occ,
  output logic          full,
  output logic          empty
);
  import wtsb_pkg::*;

  logic [CW-1:0] occ_nx;

  always_comb begin
    pop_fire  = drain_ready && !empty;
    push_fire = st_valid && (!full || pop_fire);
    occ_nx    = occ;
    if (push_fire && !pop_fire)      occ_nx = occ + 1'b1;
    else if (pop_fire && !push_fire) occ_nx = occ - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
    end else begin
      if (push_fire) wr_ptr <= PW'(ring_next(int'(wr_ptr), DEPTH));
      if (pop_fire)  rd_ptr <= PW'(ring_next(int'(rd_ptr), DEPTH));
      occ   <= occ_nx;
      full  <= (occ_nx == CW'(DEPTH));
      empty <= (occ_nx == '0);
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH));

  a_r4_full_blocks: assert property (@(posedge clk) disable iff (rst)
    full && st_valid && !drain_ready |=> full && $stable(occ));

  a_r5_full_swap: assert property (@(posedge clk) disable iff (rst)
    full && st_valid && drain_ready |=> full);

  a_r6_empty_hold: assert property (@(posedge clk) disable iff (rst)
    empty && drain_ready && !st_valid |=> empty);

  a_r7_full_release: assert property (@(posedge clk) disable iff (rst)
    full && drain_ready && !st_valid |=> !full);

endmodule

// File: rtl/wtsb_store.sv
module wtsb_store #(
  parameter int DEPTH = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int BW = DW / 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [PW-1:0]            wr_ptr,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic [BW-1:0]            wr_be,
  input  logic [PW-1:0]            rd_ptr,
  output logic [AW-1:0]            head_addr,
  output logic [DW-1:0]            head_data,
  output logic [BW-1:0]            head_be,
  output logic [DEPTH-1:0][AW-1:0] all_addr,
  output logic [DEPTH-1:0][DW-1:0] all_data,
  output logic [DEPTH-1:0][BW-1:0] all_be
);

  logic [AW-1:0] addr_mem [DEPTH];
  logic [DW-1:0] data_mem [DEPTH];
  logic [BW-1:0] be_mem   [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      addr_mem[wr_ptr] <= wr_addr;
      data_mem[wr_ptr] <= wr_data;
      be_mem[wr_ptr]   <= wr_be;
    end
  end

  always_comb begin
    head_addr = addr_mem[rd_ptr];
    head_data = data_mem[rd_ptr];
    head_be   = be_mem[rd_ptr];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign all_addr[g] = addr_mem[g];
    assign all_data[g] = data_mem[g];
    assign all_be[g]   = be_mem[g];
  end

endmodule

// File: rtl/wtsb_match.sv
module wtsb_match #(
  parameter int DEPTH = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int BW = DW / 8,
  localparam int OFS = $clog2(BW),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     probe_req,
  input  logic [AW-1:0]            probe_addr,
  input  logic [PW-1:0]            rd_ptr,
  input  logic [CW-1:0]            occ,
  input  logic [DEPTH-1:0][AW-1:0] all_addr,
  input  logic [DEPTH-1:0][DW-1:0] all_data,
  input  logic [DEPTH-1:0][BW-1:0] all_be,
  output logic                     probe_hit,
  output logic                     probe_partial,
  output logic [DW-1:0]            probe_data
);
  import wtsb_pkg::*;

  logic          found;
  logic [DW-1:0] sel_data;
  logic [BW-1:0] sel_be;
  logic [PW-1:0] slot;
  lk_res_e       res;

  // Walk from oldest to youngest so the last match kept is the youngest.
  always_comb begin
    found    = 1'b0;
    sel_data = '0;
    sel_be   = '0;
    slot     = '0;
    for (int i = 0; i < DEPTH; i++) begin
      slot = PW'((int'(rd_ptr) + i) % DEPTH);
      if (i < int'(occ) && all_addr[slot][AW-1:OFS] == probe_addr[AW-1:OFS]) begin
        found    = 1'b1;
        sel_data = all_data[slot];
        sel_be   = all_be[slot];
      end
    end
    if (!probe_req || !found) res = LK_NONE;
    else if (&sel_be)         res = LK_FULL;
    else                      res = LK_PART;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      probe_hit     <= 1'b0;
      probe_partial <= 1'b0;
      probe_data    <= '0;
    end else begin
      probe_hit     <= (res == LK_FULL);
      probe_partial <= (res == LK_PART);
      probe_data    <= (res == LK_FULL) ? sel_data : '0;
    end
  end

  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(probe_hit && probe_partial));

  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    !probe_req |=> !probe_hit && !probe_partial);

  a_r10_empty_miss: assert property (@(posedge clk) disable iff (rst)
    probe_req && occ == '0 |=> !probe_hit && !probe_partial);

endmodule

// File: rtl/wt_store_buf.sv
module wt_store_buf #(
  parameter int DEPTH = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int BW = DW / 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic [BW-1:0] st_be,
  output logic          full,
  output logic          empty,
  input  logic          drain_ready,
  output logic          drain_valid,
  output logic [AW-1:0] drain_addr,
  output logic [DW-1:0] drain_data,
  output logic [BW-1:0] drain_be,
  input  logic          probe_req,
  input  logic [AW-1:0] probe_addr,
  output logic          probe_hit,
  output logic          probe_partial,
  output logic [DW-1:0] probe_data
);

  logic                     push_fire, pop_fire;
  logic [PW-1:0]            wr_ptr, rd_ptr;
  logic [CW-1:0]            occ;
  logic [DEPTH-1:0][AW-1:0] all_addr;
  logic [DEPTH-1:0][DW-1:0] all_data;
  logic [DEPTH-1:0][BW-1:0] all_be;

  wtsb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .st_valid(st_valid), .drain_ready(drain_ready),
    .push_fire(push_fire), .pop_fire(pop_fire), .wr_ptr(wr_ptr),
    .rd_ptr(rd_ptr), .occ(occ), .full(full), .empty(empty)
  );

  wtsb_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk(clk), .wr_en(push_fire), .wr_ptr(wr_ptr), .wr_addr(st_addr),
    .wr_data(st_data), .wr_be(st_be), .rd_ptr(rd_ptr),
    .head_addr(drain_addr), .head_data(drain_data), .head_be(drain_be),
    .all_addr(all_addr), .all_data(all_data), .all_be(all_be)
  );

  wtsb_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
    .clk(clk), .rst(rst), .probe_req(probe_req), .probe_addr(probe_addr),
    .rd_ptr(rd_ptr), .occ(occ), .all_addr(all_addr), .all_data(all_data),
    .all_be(all_be), .probe_hit(probe_hit), .probe_partial(probe_partial),
    .probe_data(probe_data)
  );

  assign drain_valid = !empty;

  a_r2_pop_only_when_valid: assert property (@(posedge clk) disable iff (rst)
    pop_fire |-> drain_valid);

endmodule

// File: tb/test_wt_store_buf.sv
module test_wt_store_buf;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic [31:0] st_data = '0;
  logic [3:0]  st_be = '0;
  logic        drain_ready = 1'b0;
  logic        probe_req = 1'b0;
  logic [31:0] probe_addr = '0;
  logic        full, empty, drain_valid, probe_hit, probe_partial;
  logic [31:0] drain_addr, drain_data, probe_data;
  logic [3:0]  drain_be;

  wt_store_buf i_wt_store_buf (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .st_be(st_be), .full(full), .empty(empty),
    .drain_ready(drain_ready), .drain_valid(drain_valid),
    .drain_addr(drain_addr), .drain_data(drain_data), .drain_be(drain_be),
    .probe_req(probe_req), .probe_addr(probe_addr), .probe_hit(probe_hit),
    .probe_partial(probe_partial), .probe_data(probe_data)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    logic [3:0]  b;
  } ent_t;

  ent_t  q[$];
  int    total = 0;
  int    bad = 0;
  int    cycles = 0;
  bit    done = 0;
  bit    exp_hit = 0;
  bit    exp_part = 0;
  logic [31:0] exp_pdata = '0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    chk(req, "empty", 32'(empty), 32'(q.size() == 0));
    chk(req, "full", 32'(full), 32'(q.size() == 4));
    chk(req, "drain_valid", 32'(drain_valid), 32'(q.size() != 0));
    if (q.size() != 0) begin
      chk(req, "drain_addr", drain_addr, q[0].a);
      chk(req, "drain_data", drain_data, q[0].d);
      chk(req, "drain_be", 32'(drain_be), 32'(q[0].b));
    end
    chk(req, "probe_hit", 32'(probe_hit), 32'(exp_hit));
    chk(req, "probe_partial", 32'(probe_partial), 32'(exp_part));
    if (exp_hit) chk(req, "probe_data", probe_data, exp_pdata);
  endtask

  // One clock: drive, update the behavioural model, check after the edge.
  task automatic cyc(input string req, input bit sv, input logic [31:0] sa,
                     input logic [31:0] sd, input logic [3:0] sb, input bit dr,
                     input bit pr, input logic [31:0] pa);
    bit pop_ok, push_ok, found;
    ent_t m;
    st_valid = sv; st_addr = sa; st_data = sd; st_be = sb;
    drain_ready = dr; probe_req = pr; probe_addr = pa;
    found = 0;
    m = '{a: '0, d: '0, b: '0};
    foreach (q[k]) if (q[k].a[31:2] == pa[31:2]) begin found = 1; m = q[k]; end
    exp_hit   = pr && found && (m.b == 4'hF);
    exp_part  = pr && found && (m.b != 4'hF);
    exp_pdata = m.d;
    pop_ok  = dr && q.size() > 0;
    push_ok = sv && (q.size() < 4 || pop_ok);
    if (pop_ok)  void'(q.pop_front());
    if (push_ok) q.push_back('{a: sa, d: sd, b: sb});
    @(posedge clk);
    #2;
    compare(req);
  endtask

  task automatic idle(input string req);
    cyc(req, 0, '0, '0, '0, 0, 0, '0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    exp_hit = 0; exp_part = 0;
    compare("R1");
    rst = 1'b0;
    idle("R1");

    // R3: fill to four entries; the same word appears twice.
    cyc("R3", 1, 32'h100, 32'hA0A0_0001, 4'hF, 0, 0, '0);
    cyc("R3", 1, 32'h104, 32'hA0A0_0002, 4'h3, 0, 0, '0);
    cyc("R3", 1, 32'h108, 32'hA0A0_0003, 4'hF, 0, 0, '0);
    cyc("R3", 1, 32'h100, 32'hA0A0_0004, 4'hF, 0, 0, '0);
    idle("R3");

    // R4: offered store while full and no drain is lost.
    cyc("R4", 1, 32'h200, 32'hDEAD_0200, 4'hF, 0, 0, '0);
    cyc("R4", 0, '0, '0, '0, 0, 1, 32'h200);

    // R8, R9, R10: lookup outcomes.
    cyc("R8", 0, '0, '0, '0, 0, 1, 32'h102);
    cyc("R9", 0, '0, '0, '0, 0, 1, 32'h104);
    cyc("R10", 0, '0, '0, '0, 0, 1, 32'h300);
    idle("R10");

    // R5: store and drain together while full.
    cyc("R5", 1, 32'h10C, 32'hA0A0_0005, 4'hE, 1, 0, '0);
    idle("R5");

    // R11: a drained entry is still seen; a same-cycle store is not.
    cyc("R11", 0, '0, '0, '0, 1, 1, 32'h104);
    cyc("R11", 1, 32'h110, 32'hA0A0_0006, 4'hF, 0, 1, 32'h110);
    cyc("R11", 0, '0, '0, '0, 0, 1, 32'h110);

    // R7: full clears the cycle after a lone drain.
    cyc("R7", 0, '0, '0, '0, 1, 0, '0);
    idle("R7");

    // R2: drain everything in order.
    for (int i = 0; i < 4; i++) cyc("R2", 0, '0, '0, '0, 1, 0, '0);

    // R6: drain requests on an empty queue.
    for (int i = 0; i < 3; i++) cyc("R6", 0, '0, '0, '0, 1, 0, '0);
    cyc("R6", 1, 32'h120, 32'hA0A0_0007, 4'hF, 0, 0, '0);
    cyc("R6", 0, '0, '0, '0, 1, 0, '0);

    // Random mix of stores, drains and lookups over a small word pool.
    for (int i = 0; i < 600; i++) begin
      logic [31:0] ra, pa;
      logic [3:0] rb;
      ra = 32'h40 + 32'($urandom_range(0, 3) * 4) + 32'($urandom_range(0, 3));
      pa = 32'h40 + 32'($urandom_range(0, 4) * 4) + 32'($urandom_range(0, 3));
      rb = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'hF;
      cyc("R2", $urandom_range(0, 1) == 1, ra, $urandom, rb,
          $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, pa);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule